// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible face of a sixteen-channel DMA controller. A host issues single-cycle reads and writes on a plain 32-bit register bus. The block keeps, for each channel, a buffer address, a line length, a line count, a line pitch and a small control word. It presents all of them as parallel outputs to the channel engines that sit beside it. A write to a channel's buffer-address register also launches that channel: the channel gets a one-cycle start pulse in the cycle after the write, and the new address is already visible on its outputs in that cycle.

A small set of shared words handles the channels as a group. A stop word sends one-cycle abort pulses. An event status word collects the completion pulses that the engines return, and the host clears it by writing ones. An interrupt mask combines with the status into a single interrupt line. A loop word keeps a channel re-running its buffer. The mask and the loop word each have a plain read/write address and a second address where written ones clear bits, so software can change one channel without a read-modify-write. Looping for a channel is on only while both of its two loop bits are set. Clearing either bit pauses looping, and setting both again resumes it.

Top module: `dmac_regfile`

## Requirements
- R1: After reset every register reads zero, and start, stop, loop, burst, direction, all channel fields and the interrupt line are all low.
- R2: Channel c owns a 16-byte group at c*0x10. Offset 0x0 is the buffer address (32 bits), 0x4 the line length and 0x8 the line count (LEN_W bits each, upper write bits dropped), and 0xC the control word (6 bits). Each reads back what was written and drives the matching channel output.
- R3: The line pitch of channel c is at 0x100 + c*4. It is LEN_W bits wide, reads back, and drives that channel's pitch output.
- R4: In the control word, bits [3:0] hold a channel-number field that is only stored. Bit 4 drives the channel's burst output and bit 5 drives its direction output. A control write never starts the channel.
- R5: A write to the buffer-address register of channel c raises only start bit c, for exactly the one cycle after the write. No other write produces a start pulse.
- R6: Writing to 0x140 raises stop bit c for one cycle for every bit c set in the write data. Reading 0x140 returns zero.
- R7: An event pulse on channel c sets bit c of the status word at 0x144 on the next clock edge. The bit stays set until software clears it.
- R8: Writing to 0x144 clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. An event that arrives in the same cycle as the clear of its bit keeps that bit set.
- R9: The interrupt mask at 0x148 is plain read/write. Ones written to 0x14C clear the matching mask bits. A read of 0x14C returns the mask.
- R10: The interrupt line is high exactly when some channel has both its status bit and its mask bit set. It follows those registers with no further delay, so it rises in the cycle after the event.
- R11: The loop word at 0x150 uses bit c and bit c+16 for channel c, and the loop output of channel c is high only while both bits are set. Ones written to 0x15C clear loop bits, and a read of 0x15C returns the loop word.
- R12: Address bits [1:0] are ignored. Any address outside the map reads zero, and a write there changes no register and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, zero when no read |
| ch_event | input | NCH | Completion pulses from the channel engines |
| ch_start | output | NCH | One-cycle start pulses |
| ch_stop | output | NCH | One-cycle stop pulses |
| ch_loop | output | NCH | Loop enable per channel |
| ch_burst | output | NCH | Burst mode per channel |
| ch_dir | output | NCH | Direction per channel |
| ch_base_addr | output | NCH*32 | Buffer address, channel c at [c*32 +: 32] |
| ch_xlen | output | NCH*LEN_W | Line length per channel |
| ch_ylen | output | NCH*LEN_W | Line count per channel |
| ch_width | output | NCH*LEN_W | Line pitch per channel |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong decode shows up at once. A field lands in a neighbour channel or register, and the sweep over all sixteen channels reads it back at the wrong place. A stray or missing start or stop pulse is visible on the cycle after the write. A status bit that loses an event, or that ignores a clear, changes both the status read and the interrupt line within one cycle. A loop word that mixes up the bit pairs shows on the loop output after a single write.

// File: rtl/dmac_rf_pkg.sv
package dmac_rf_pkg;
  localparam int RF_AW  = 12;
  localparam int RF_DW  = 32;
  localparam int MAX_CH = 16;
  localparam int CHW    = 4;
  localparam int CTRL_W = 6;

  localparam logic [RF_AW-1:0] OFS_PITCH    = 12'h100;
  localparam logic [RF_AW-1:0] OFS_STOP     = 12'h140;
  localparam logic [RF_AW-1:0] OFS_STAT     = 12'h144;
  localparam logic [RF_AW-1:0] OFS_MASK     = 12'h148;
  localparam logic [RF_AW-1:0] OFS_MASK_CLR = 12'h14C;
  localparam logic [RF_AW-1:0] OFS_LOOP     = 12'h150;
  localparam logic [RF_AW-1:0] OFS_LOOP_CLR = 12'h15C;

  typedef enum logic [3:0] {
    RK_NONE, RK_ADDR, RK_XLEN, RK_YLEN, RK_CTRL, RK_PITCH,
    RK_STOP, RK_STAT, RK_MASK, RK_MASK_CLR, RK_LOOP, RK_LOOP_CLR
  } rf_kind_e;

  typedef struct packed {
    rf_kind_e       kind;
    logic [CHW-1:0] ch;
  } rf_hit_t;

  // Map a byte address to a register kind and channel index.
  function automatic rf_hit_t rf_decode(input logic [RF_AW-1:0] a, input int nch);
    rf_hit_t h;
    logic [RF_AW-1:0] w;
    logic [RF_AW-1:0] d;
    w = {a[RF_AW-1:2], 2'b00};
    d = w - OFS_PITCH;
    h.kind = RK_NONE;
    h.ch   = '0;
    if (int'(w) < nch * 16) begin
      h.ch = w[7:4];
      case (w[3:2])
        2'd0:    h.kind = RK_ADDR;
        2'd1:    h.kind = RK_XLEN;
        2'd2:    h.kind = RK_YLEN;
        default: h.kind = RK_CTRL;
      endcase
    end else if (w >= OFS_PITCH && int'(w) < int'(OFS_PITCH) + nch * 4) begin
      h.kind = RK_PITCH;
      h.ch   = d[5:2];
    end else begin
      case (w)
        OFS_STOP:     h.kind = RK_STOP;
        OFS_STAT:     h.kind = RK_STAT;
        OFS_MASK:     h.kind = RK_MASK;
        OFS_MASK_CLR: h.kind = RK_MASK_CLR;
        OFS_LOOP:     h.kind = RK_LOOP;
        OFS_LOOP_CLR: h.kind = RK_LOOP_CLR;
        default:      h.kind = RK_NONE;
      endcase
    end
    return h;
  endfunction

  // Writable bits of the loop word: bit c and bit c+16 for each channel.
  function automatic logic [RF_DW-1:0] pair_mask(input int nch);
    logic [RF_DW-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_CH; i++) begin
      if (i < nch) begin
        m[i]          = 1'b1;
        m[i + MAX_CH] = 1'b1;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/dmac_rf_decode.sv
module dmac_rf_decode import dmac_rf_pkg::*; #(
  parameter int NCH = 16
) (
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [RF_AW-1:0] bus_addr,
  output rf_kind_e         wr_kind,
  output logic [NCH-1:0]   wr_chan,
  output rf_kind_e         rd_kind,
  output logic [CHW-1:0]   rd_ch
);
  rf_hit_t hit;
  logic    wr_act;
  logic    rd_act;
  logic    chan_kind;

  always_comb begin
    hit       = rf_decode(bus_addr, NCH);
    wr_act    = bus_sel && bus_we;
    rd_act    = bus_sel && !bus_we;
    chan_kind = (hit.kind == RK_ADDR) || (hit.kind == RK_XLEN) ||
                (hit.kind == RK_YLEN) || (hit.kind == RK_CTRL) ||
                (hit.kind == RK_PITCH);
    wr_kind   = wr_act ? hit.kind : RK_NONE;
    rd_kind   = rd_act ? hit.kind : RK_NONE;
    rd_ch     = hit.ch;
    wr_chan   = (wr_act && chan_kind) ? (NCH'(1) << hit.ch) : '0;
  end
endmodule

// File: rtl/dmac_rf_chan.sv
module dmac_rf_chan import dmac_rf_pkg::*; #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  rf_kind_e         wr_kind,
  input  logic [RF_DW-1:0] wdata,
  input  rf_kind_e         rd_kind,
  output logic [RF_DW-1:0] base_addr,
  output logic [LEN_W-1:0] xlen,
  output logic [LEN_W-1:0] ylen,
  output logic [LEN_W-1:0] pitch,
  output logic             burst,
  output logic             dir,
  output logic             start,
  output logic [RF_DW-1:0] rd_word
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      xlen      <= '0;
      ylen      <= '0;
      pitch     <= '0;
      ctrl_q    <= '0;
      start     <= 1'b0;
    end else begin
      start <= we && (wr_kind == RK_ADDR);
      if (we) begin
        case (wr_kind)
          RK_ADDR:  base_addr <= wdata;
          RK_XLEN:  xlen      <= wdata[LEN_W-1:0];
          RK_YLEN:  ylen      <= wdata[LEN_W-1:0];
          RK_CTRL:  ctrl_q    <= wdata[CTRL_W-1:0];
          RK_PITCH: pitch     <= wdata[LEN_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign burst = ctrl_q[4];
  assign dir   = ctrl_q[5];

  always_comb begin
    case (rd_kind)
      RK_ADDR:  rd_word = base_addr;
      RK_XLEN:  rd_word = RF_DW'(xlen);
      RK_YLEN:  rd_word = RF_DW'(ylen);
      RK_CTRL:  rd_word = RF_DW'(ctrl_q);
      RK_PITCH: rd_word = RF_DW'(pitch);
      default:  rd_word = '0;
    endcase
  end
endmodule

// File: rtl/dmac_rf_irq.sv
module dmac_rf_irq #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev,
  input  logic           stat_we,
  input  logic           mask_we,
  input  logic           mask_clr_we,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] stat_q,
  output logic [NCH-1:0] mask_q,
  output logic           irq
);
  // Clear first, then let fresh events win.
  function automatic logic [NCH-1:0] stat_next(input logic [NCH-1:0] s,
                                               input logic [NCH-1:0] clr,
                                               input logic [NCH-1:0] e);
    return (s & ~clr) | e;
  endfunction

  logic [NCH-1:0] clr_bits;
  assign clr_bits = stat_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_next(stat_q, clr_bits, ev);
      if (mask_we)          mask_q <= wdata;
      else if (mask_clr_we) mask_q <= mask_q & ~wdata;
    end
  end

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/dmac_rf_loop.sv
module dmac_rf_loop import dmac_rf_pkg::*; #(
  parameter int NCH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loop_we,
  input  logic             loop_clr_we,
  input  logic [RF_DW-1:0] wdata,
  output logic [RF_DW-1:0] loop_q,
  output logic [NCH-1:0]   ch_loop
);
  localparam logic [RF_DW-1:0] LMASK = pair_mask(NCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           loop_q <= '0;
    else if (loop_we)     loop_q <= wdata & LMASK;
    else if (loop_clr_we) loop_q <= loop_q & ~wdata;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_pair
    assign ch_loop[c] = loop_q[c] & loop_q[c + MAX_CH];
  end
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile import dmac_rf_pkg::*; #(
  parameter int NCH   = 16,
  parameter int LEN_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [RF_AW-1:0]     bus_addr,
  input  logic [RF_DW-1:0]     bus_wdata,
  output logic [RF_DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]       ch_event,
  output logic [NCH-1:0]       ch_start,
  output logic [NCH-1:0]       ch_stop,
  output logic [NCH-1:0]       ch_loop,
  output logic [NCH-1:0]       ch_burst,
  output logic [NCH-1:0]       ch_dir,
  output logic [NCH*RF_DW-1:0] ch_base_addr,
  output logic [NCH*LEN_W-1:0] ch_xlen,
  output logic [NCH*LEN_W-1:0] ch_ylen,
  output logic [NCH*LEN_W-1:0] ch_width,
  output logic                 irq
);
  // Named internal events, also used by the bound checker.
  rf_kind_e         wr_kind_w;
  rf_kind_e         rd_kind_w;
  logic [NCH-1:0]   wr_chan_w;
  logic [CHW-1:0]   rd_ch_w;
  logic [NCH-1:0]   irq_stat_w;
  logic [NCH-1:0]   irq_mask_w;
  logic [RF_DW-1:0] loop_word_w;
  logic [NCH-1:0]   stop_q;
  logic [RF_DW-1:0] chan_rd [NCH];

  dmac_rf_decode #(.NCH(NCH)) dec_i (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .wr_kind (wr_kind_w),
    .wr_chan (wr_chan_w),
    .rd_kind (rd_kind_w),
    .rd_ch   (rd_ch_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dmac_rf_chan #(.LEN_W(LEN_W)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (wr_chan_w[c]),
      .wr_kind  (wr_kind_w),
      .wdata    (bus_wdata),
      .rd_kind  (rd_kind_w),
      .base_addr(ch_base_addr[c*RF_DW +: RF_DW]),
      .xlen     (ch_xlen[c*LEN_W +: LEN_W]),
      .ylen     (ch_ylen[c*LEN_W +: LEN_W]),
      .pitch    (ch_width[c*LEN_W +: LEN_W]),
      .burst    (ch_burst[c]),
      .dir      (ch_dir[c]),
      .start    (ch_start[c]),
      .rd_word  (chan_rd[c])
    );
  end

  dmac_rf_irq #(.NCH(NCH)) irq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ch_event),
    .stat_we    (wr_kind_w == RK_STAT),
    .mask_we    (wr_kind_w == RK_MASK),
    .mask_clr_we(wr_kind_w == RK_MASK_CLR),
    .wdata      (bus_wdata[NCH-1:0]),
    .stat_q     (irq_stat_w),
    .mask_q     (irq_mask_w),
    .irq        (irq)
  );

  dmac_rf_loop #(.NCH(NCH)) loop_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .loop_we    (wr_kind_w == RK_LOOP),
    .loop_clr_we(wr_kind_w == RK_LOOP_CLR),
    .wdata      (bus_wdata),
    .loop_q     (loop_word_w),
    .ch_loop    (ch_loop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= '0;
    else        stop_q <= (wr_kind_w == RK_STOP) ? bus_wdata[NCH-1:0] : '0;
  end
  assign ch_stop = stop_q;

  always_comb begin
    case (rd_kind_w)
      RK_ADDR, RK_XLEN, RK_YLEN, RK_CTRL, RK_PITCH: bus_rdata = chan_rd[rd_ch_w];
      RK_STAT:                bus_rdata = RF_DW'(irq_stat_w);
      RK_MASK, RK_MASK_CLR:   bus_rdata = RF_DW'(irq_mask_w);
      RK_LOOP, RK_LOOP_CLR:   bus_rdata = loop_word_w;
      default:                bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmac_rf_chk.sv
module dmac_rf_chk import dmac_rf_pkg::*; #(
  parameter int NCH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [RF_AW-1:0] bus_addr,
  input logic [NCH-1:0]   wlow,
  input logic [NCH-1:0]   ch_start,
  input logic [NCH-1:0]   ch_stop,
  input logic [NCH-1:0]   ch_event,
  input logic             irq,
  input logic [NCH-1:0]   stat,
  input logic [NCH-1:0]   mask
);
  rf_hit_t        hit;
  logic           wr;
  logic [NCH-1:0] hot;

  always_comb begin
    hit = rf_decode(bus_addr, NCH);
    wr  = bus_sel && bus_we;
    hot = NCH'(1) << hit.ch;
  end

  AST_START_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit.kind == RK_ADDR) |=> (ch_start == $past(hot))); // R5
  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && hit.kind == RK_ADDR) |=> (ch_start == '0)); // R5
  AST_STOP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit.kind == RK_STOP) |=> (ch_stop == $past(wlow))); // R6
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && hit.kind == RK_STOP) |=> (ch_stop == '0)); // R6
  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_event) |=> ((stat & $past(ch_event)) == $past(ch_event))); // R7
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && hit.kind == RK_STAT) |=> ((stat & $past(stat)) == $past(stat))); // R8
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit.kind == RK_MASK_CLR) |=> ((mask & $past(wlow)) == '0)); // R9
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R10
endmodule

bind dmac_regfile dmac_rf_chk #(.NCH(NCH)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_sel (bus_sel),
  .bus_we  (bus_we),
  .bus_addr(bus_addr),
  .wlow    (bus_wdata[NCH-1:0]),
  .ch_start(ch_start),
  .ch_stop (ch_stop),
  .ch_event(ch_event),
  .irq     (irq),
  .stat    (irq_stat_w),
  .mask    (irq_mask_w)
);

// File: tb/dmac_regfile_tb_top.sv
`timescale 1ns/1ps
module dmac_regfile_tb_top;
  localparam int NCH   = 16;
  localparam int LEN_W = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 sel = 1'b0;
  logic                 we = 1'b0;
  logic [11:0]          addr = '0;
  logic [31:0]          wdata = '0;
  logic [31:0]          rdata;
  logic [NCH-1:0]       ev = '0;
  logic [NCH-1:0]       start, stop, lp, burst, dir;
  logic [NCH*32-1:0]    baddr;
  logic [NCH*LEN_W-1:0] xl, yl, wd;
  logic                 irq;

  int  ntests = 0;
  int  nfail  = 0;
  bit  done   = 0;

  always #2.5 clk = ~clk;

  dmac_regfile #(.NCH(NCH), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .ch_event(ev), .ch_start(start),
    .ch_stop(stop), .ch_loop(lp), .ch_burst(burst), .ch_dir(dir),
    .ch_base_addr(baddr), .ch_xlen(xl), .ch_ylen(yl), .ch_width(wd), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic pulse_event(input logic [NCH-1:0] e);
    @(negedge clk);
    ev = e;
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] expst;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 start", 32'(start), 0);
    check("R1 stop", 32'(stop), 0);
    check("R1 loop", 32'(lp), 0);
    check("R1 burst/dir", 32'({burst, dir}), 0);
    check("R1 base", 32'(|baddr), 0);
    rd(12'h144, v); check("R1 status", v, 0);
    rd(12'h148, v); check("R1 mask", v, 0);
    rd(12'h150, v); check("R1 loop word", v, 0);
    rd(12'h0F0, v); check("R1 ch15 addr", v, 0);

    // R2 R3 R4 R5: sweep every channel
    for (int c = 0; c < NCH; c++) begin
      logic [31:0] ea;
      logic [15:0] ex, ey, ew;
      logic [31:0] ec;
      ea = 32'hA500_0000 + 32'(c) * 32'h0001_0203;
      ex = 16'h0100 + 16'(c);
      ey = 16'h0200 + 16'(c * 3);
      ew = 16'h0040 + 16'(c);
      ec = 32'(c) | (32'(c & 1) << 4) | (32'((c >> 1) & 1) << 5);

      wr(12'(c * 16), ea);
      check("R5 start pulse", 32'(start), 32'(1) << c);
      check("R2 base out", baddr[c*32 +: 32], ea);
      @(negedge clk);
      check("R5 start one cycle", 32'(start), 0);

      wr(12'(c * 16 + 4), 32'hDEAD_0000 | 32'(ex));
      check("R5 no start on xlen", 32'(start), 0);
      wr(12'(c * 16 + 8), 32'hBEEF_0000 | 32'(ey));
      wr(12'(c * 16 + 12), 32'hFFFF_FFC0 | ec);
      check("R4 no start on ctrl", 32'(start), 0);
      wr(12'h100 + 12'(c * 4), 32'h1234_0000 | 32'(ew));

      rd(12'(c * 16) | 12'h3, v); check("R12 byte offset ignored", v, ea);
      rd(12'(c * 16 + 4), v);     check("R2 xlen read", v, 32'(ex));
      rd(12'(c * 16 + 8), v);     check("R2 ylen read", v, 32'(ey));
      rd(12'(c * 16 + 12), v);    check("R4 ctrl read", v, ec);
      rd(12'h100 + 12'(c * 4), v); check("R3 pitch read", v, 32'(ew));
      check("R2 xlen out", 32'(xl[c*LEN_W +: LEN_W]), 32'(ex));
      check("R2 ylen out", 32'(yl[c*LEN_W +: LEN_W]), 32'(ey));
      check("R3 pitch out", 32'(wd[c*LEN_W +: LEN_W]), 32'(ew));
      check("R4 burst", 32'(burst[c]), 32'(c & 1));
      check("R4 dir", 32'(dir[c]), 32'((c >> 1) & 1));
    end
    rd(12'h000, v); check("R2 ch0 addr kept", v, 32'hA500_0000);
    rd(12'h0F4, v); check("R2 ch15 xlen kept", v, 32'h0000_010F);

    // R6: stop pulses
    for (int k = 0; k < 4; k++) begin
      logic [15:0] p;
      p = 16'h8001 << k ^ 16'(k * 16'h1111);
      wr(12'h140, 32'hFFFF_0000 | 32'(p));
      check("R6 stop pulse", 32'(stop), 32'(p));
      @(negedge clk);
      check("R6 stop one cycle", 32'(stop), 0);
    end
    rd(12'h140, v); check("R6 stop reads zero", v, 0);

    // R7: events accumulate
    expst = 0;
    for (int c = 0; c < NCH; c++) begin
      pulse_event(16'(1) << c);
      expst = expst | (32'(1) << c);
      rd(12'h144, v); check("R7 status set", v, expst);
    end
    // R8: write-one-to-clear
    wr(12'h144, 32'h0000_00F0); expst = expst & ~32'h00F0;
    rd(12'h144, v); check("R8 w1c", v, expst);
    wr(12'h144, 32'h0); rd(12'h144, v); check("R8 zero write keeps", v, expst);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = 12'h144; wdata = 32'h3; ev = 16'h0001;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; ev = '0;
    expst = (expst & ~32'h3) | 32'h1;
    rd(12'h144, v); check("R8 event beats clear", v, expst);

    // R9 R10: mask and interrupt
    check("R10 irq low mask zero", 32'(irq), 0);
    wr(12'h148, 32'h0000_0002); check("R10 masked-off bit", 32'(irq), 0);
    wr(12'h148, 32'h0000_0004); check("R10 irq high", 32'(irq), 1);
    wr(12'h14C, 32'h0000_0004); check("R10 irq after mask clear", 32'(irq), 0);
    rd(12'h14C, v); check("R9 clear alias reads mask", v, 0);
    wr(12'h148, 32'hFFFF_FFFF);
    rd(12'h148, v); check("R9 mask width", v, 32'h0000_FFFF);
    wr(12'h14C, 32'h0000_0F00);
    rd(12'h14C, v); check("R9 partial clear", v, 32'h0000_F0FF);
    wr(12'h148, 32'h0000_FFFF);
    wr(12'h144, 32'hFFFF_FFFF); check("R10 irq after status clear", 32'(irq), 0);
    @(negedge clk);
    ev = 16'h0080;
    #1 check("R10 irq not before edge", 32'(irq), 0);
    @(negedge clk);
    ev = '0;
    check("R10 irq after event", 32'(irq), 1);
    rd(12'h144, v); check("R7 status ch7", v, 32'h0080);

    // R11: loop pairs
    for (int c = 0; c < NCH; c++) begin
      logic [31:0] lo, hi;
      lo = 32'(1) << c;
      hi = 32'(1) << (c + 16);
      wr(12'h150, lo);      check("R11 one bit no loop", 32'(lp), 0);
      wr(12'h150, lo | hi); check("R11 both bits loop", 32'(lp), lo);
      wr(12'h15C, hi);      check("R11 pause", 32'(lp), 0);
      rd(12'h15C, v);       check("R11 clear alias reads", v, lo);
      wr(12'h150, lo | hi); check("R11 resume", 32'(lp), lo);
    end
    wr(12'h15C, 32'hFFFF_FFFF);
    rd(12'h150, v); check("R11 all cleared", v, 0);
    wr(12'h150, 32'h0003_0003);

    // R12: unmapped addresses
    for (int a = 12'h154; a < 12'h200; a += 4) begin
      if (a != 12'h15C) begin
        wr(12'(a), 32'hFFFF_FFFF);
        check("R12 no pulse", 32'({start, stop}), 0);
        rd(12'(a), v); check("R12 unmapped zero", v, 0);
      end
    end
    wr(12'hFFC, 32'hFFFF_FFFF); rd(12'hFFC, v); check("R12 top zero", v, 0);
    rd(12'h148, v); check("R12 mask untouched", v, 32'h0000_FFFF);
    rd(12'h150, v); check("R12 loop untouched", v, 32'h0003_0003);
    rd(12'h144, v); check("R12 status untouched", v, 32'h0080);
    rd(12'h000, v); check("R12 ch0 untouched", v, 32'hA500_0000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      ntests++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule